// File: doc/BRIEF.md
# LIN Break Detector

This block watches the receive line of a UART that carries LIN traffic and spots the synchronization break. The break is a dominant (low) period that is longer than any legal character. A bit-time tick from the baud generator paces the measurement. On each tick the block samples the line and counts how many consecutive samples have been low. When the low run exceeds eleven bit times, the block does three things in the same cycle. It sets a sticky break flag. It raises an interrupt if the interrupt is enabled. It emits a one-cycle pulse that tells the companion receiver to clear its data-ready flag and its framing, overrun and parity error flags.

A low line makes the receiver report a framing error after nine bit times. For that reason software turns the receiver off when it only wants break detection. The detector works only while the port is in an asynchronous mode, which `async_mode` signals. The host clears the flag by writing a 1 on `host_wr_data` together with `host_wr`. A write of 0 has no effect.

The controller has three states:
- IDLE: no low run is in progress.
- MEASURE: a low run is being counted.
- HELD: a break has been reported and the block waits for the line to return high.

Its transitions are:
- IDLE→MEASURE on a tick that samples low.
- MEASURE→IDLE on a tick that samples high.
- MEASURE→HELD on the twelfth consecutive low tick.
- HELD→IDLE on a tick that samples high.
- Any state→IDLE whenever `async_mode` is 0.

Top module: `lin_brk_det`

## Requirements
- R1: After reset, `brk_flag`, `brk_irq` and `rx_flags_clr` are 0.
- R2: When `bit_tick` samples `rxd`=0 on twelve consecutive ticks, `brk_flag` becomes 1 in the cycle after the clock edge of the twelfth tick. Eleven low ticks followed by a tick sampling `rxd`=1 do not set it.
- R3: A tick that samples `rxd`=1 restarts the low-run count from zero, so low samples taken before it never add to a later run.
- R4: `rx_flags_clr` is a single-cycle pulse. It is high exactly in the cycle in which `brk_flag` is first set by a detection.
- R5: One low period gives at most one detection. While the line stays low after a break, no new pulse and no new flag set occur, even if the host has cleared the flag. Detection is re-armed only by a tick that samples `rxd`=1.
- R6: A cycle with `host_wr`=1 and `host_wr_data`=1 clears `brk_flag`, and with it `brk_irq`, from the next cycle on. With `host_wr_data`=0 the write leaves the flag unchanged.
- R7: `brk_irq` is 1 exactly while `brk_flag` is 1 and `irq_en` is 1. It follows `irq_en` in the same cycle.
- R8: While `async_mode` is 0, no detection occurs and the low-run count is held at zero. A run that `async_mode`=0 interrupts starts over from zero.
- R9: If a detection and a clearing host write fall in the same cycle, the detection wins and `brk_flag` is 1 afterwards.
- R10: `rxd` is sampled only in cycles where `bit_tick` is 1. Its value in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line, 0 = dominant |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| async_mode | input | 1 | 1 when the port is in an asynchronous mode |
| irq_en | input | 1 | Break interrupt enable |
| host_wr | input | 1 | Host write strobe to the break flag |
| host_wr_data | input | 1 | Written value; 1 clears the flag |
| brk_flag | output | 1 | Break-detected flag (sticky) |
| brk_irq | output | 1 | Break interrupt request |
| rx_flags_clr | output | 1 | One-cycle pulse clearing receiver ready/error flags |

## Verification
Two events can land in the same cycle: a detection setting the flag, and a host write trying to clear it. The bench provokes this by asserting a clearing write exactly in the cycle of the twelfth low tick. It then expects the flag to stay set, with the pulse present. A second collision test clears the flag in the cycle while the line is still low. That test confirms that no re-detection follows until a high tick is seen. Every cycle is judged against a behavioural reference model that runs beside the design.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_HELD    = 2'd2
    } brk_state_t;

endpackage

// File: rtl/lin_brk_lowtimer.sv
module lin_brk_lowtimer #(
    parameter int LIMIT = 12,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          last_step
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    // last_step: the next increment completes the run
    always_comb begin
        last_step = (count == LAST);
    end

    // R3
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count < CW'(LIMIT));

endmodule

// File: rtl/lin_brk_fsm.sv
module lin_brk_fsm
    import lin_brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_mode,
    input  logic bit_tick,
    input  logic rxd,
    input  logic last_step,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic detect
);

    brk_state_t state, state_nx;
    logic       low_tick;
    logic       high_tick;

    always_comb begin
        low_tick  = bit_tick && !rxd;
        high_tick = bit_tick && rxd;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        detect   = 1'b0;
        if (!async_mode) begin
            state_nx = ST_IDLE;
            cnt_clr  = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (low_tick) begin
                        cnt_inc  = 1'b1;
                        state_nx = ST_MEASURE;
                    end else if (high_tick) begin
                        cnt_clr = 1'b1;
                    end
                end
                ST_MEASURE: begin
                    if (high_tick) begin
                        cnt_clr  = 1'b1;
                        state_nx = ST_IDLE;
                    end else if (low_tick) begin
                        if (last_step) begin
                            detect   = 1'b1;
                            cnt_clr  = 1'b1;
                            state_nx = ST_HELD;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                ST_HELD: begin
                    cnt_clr = 1'b1;
                    if (high_tick) begin
                        state_nx = ST_IDLE;
                    end
                end
                default: begin
                    state_nx = ST_IDLE;
                    cnt_clr  = 1'b1;
                end
            endcase
        end
    end

    // R5
    held_until_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && async_mode && !high_tick) |=> (state == ST_HELD));

    // R5
    no_detect_in_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD) |-> !detect);

    // R10
    no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && async_mode) |=> $stable(state));

endmodule

// File: rtl/lin_brk_flag.sv
module lin_brk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic detect,
    input  logic host_wr,
    input  logic host_wr_data,
    input  logic irq_en,
    output logic brk_flag,
    output logic brk_irq,
    output logic rx_flags_clr
);

    logic host_clear;

    always_comb begin
        host_clear = host_wr && host_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_flag     <= 1'b0;
            rx_flags_clr <= 1'b0;
        end else begin
            rx_flags_clr <= detect;
            if (detect) begin
                brk_flag <= 1'b1;
            end else if (host_clear) begin
                brk_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        brk_irq = brk_flag && irq_en;
    end

    // R6
    host_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clear && !detect) |=> !brk_flag);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detect |=> brk_flag);

    // R6
    zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_clear && !detect) |=> $stable(brk_flag));

endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
    parameter int BRK_BITS = 11,
    localparam int LIMIT = BRK_BITS + 1,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic bit_tick,
    input  logic async_mode,
    input  logic irq_en,
    input  logic host_wr,
    input  logic host_wr_data,
    output logic brk_flag,
    output logic brk_irq,
    output logic rx_flags_clr
);

    logic          cnt_clr;
    logic          cnt_inc;
    logic          last_step;
    logic          detect;
    logic [CW-1:0] low_count;

    lin_brk_lowtimer #(.LIMIT(LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .count     (low_count),
        .last_step (last_step)
    );

    lin_brk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_mode (async_mode),
        .bit_tick   (bit_tick),
        .rxd        (rxd),
        .last_step  (last_step),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .detect     (detect)
    );

    lin_brk_flag u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .detect       (detect),
        .host_wr      (host_wr),
        .host_wr_data (host_wr_data),
        .irq_en       (irq_en),
        .brk_flag     (brk_flag),
        .brk_irq      (brk_irq),
        .rx_flags_clr (rx_flags_clr)
    );

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flags_clr |=> !rx_flags_clr);

    // R4
    pulse_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flags_clr |-> brk_flag);

    // R2
    flag_rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> rx_flags_clr);

    // R7
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |-> (irq_en && brk_flag));

    // R8
    mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !async_mode |=> !rx_flags_clr);

    // R2
    low_tick_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detect |-> (bit_tick && !rxd && low_count == CW'(LIMIT - 1)));

endmodule

// File: tb/tb_lin_brk_det.sv
`timescale 1ns/1ps
module tb_lin_brk_det;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic bit_tick = 1'b0;
    logic async_mode = 1'b1;
    logic irq_en = 1'b0;
    logic host_wr = 1'b0;
    logic host_wr_data = 1'b0;
    logic brk_flag, brk_irq, rx_flags_clr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";
    bit done = 1'b0;

    // behavioural reference
    int  m_cnt = 0;
    bit  m_armed = 1'b1;
    bit  m_flag = 1'b0;
    bit  m_pulse = 1'b0;
    int  pulse_total = 0;

    always #2.5 clk = ~clk;

    lin_brk_det dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .bit_tick(bit_tick),
        .async_mode(async_mode), .irq_en(irq_en), .host_wr(host_wr),
        .host_wr_data(host_wr_data), .brk_flag(brk_flag), .brk_irq(brk_irq),
        .rx_flags_clr(rx_flags_clr)
    );

    always @(posedge clk) begin
        bit det;
        det = 1'b0;
        if (!rst_n) begin
            m_cnt = 0; m_armed = 1'b1; m_flag = 1'b0; m_pulse = 1'b0;
        end else begin
            if (!async_mode) begin
                m_cnt = 0; m_armed = 1'b1;
            end else if (bit_tick) begin
                if (rxd) begin
                    m_cnt = 0; m_armed = 1'b1;
                end else if (m_armed) begin
                    m_cnt++;
                    if (m_cnt > 11) begin
                        det = 1'b1; m_armed = 1'b0; m_cnt = 0;
                    end
                end
            end
            m_pulse = det;
            if (det) m_flag = 1'b1;
            else if (host_wr && host_wr_data) m_flag = 1'b0;
            if (det) pulse_total++;
        end
    end

    task automatic check(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        #1;
        if (!done) begin
            check("brk_flag", brk_flag, m_flag);
            check("rx_flags_clr", rx_flags_clr, m_pulse);
            check("brk_irq", brk_irq, m_flag && irq_en);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one bit time: tick in first cycle, three quiet cycles
    task automatic bits(input logic level, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rxd = level; bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
            idle(2);
        end
    endtask

    task automatic host_clear();
        @(negedge clk); host_wr = 1'b1; host_wr_data = 1'b1;
        @(negedge clk); host_wr = 1'b0; host_wr_data = 1'b0;
    endtask

    task automatic expect_now(input string what, input logic act, input logic exp);
        check(what, act, exp);
    endtask

    initial begin
        int p0;
        idle(3);
        #1;
        tag = "R1";
        expect_now("reset flag", brk_flag, 1'b0);
        expect_now("reset pulse", rx_flags_clr, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        bits(1'b1, 2);

        tag = "R2";
        bits(1'b0, 11);
        expect_now("11 lows no flag", brk_flag, 1'b0);
        bits(1'b1, 1);
        expect_now("after high no flag", brk_flag, 1'b0);
        irq_en = 1'b1;
        p0 = pulse_total;
        bits(1'b0, 12);
        expect_now("12 lows flag", brk_flag, 1'b1);
        tag = "R4";
        expect_now("one pulse", (pulse_total == p0 + 1), 1'b1);
        tag = "R7";
        expect_now("irq on", brk_irq, 1'b1);
        @(negedge clk); irq_en = 1'b0; #0.5;
        expect_now("irq follows en", brk_irq, 1'b0);
        irq_en = 1'b1;

        tag = "R5";
        host_clear();
        bits(1'b0, 20);
        expect_now("no redetect while low", brk_flag, 1'b0);
        expect_now("single pulse", (pulse_total == p0 + 1), 1'b1);

        tag = "R6";
        bits(1'b1, 1);
        bits(1'b0, 12);
        @(negedge clk); host_wr = 1'b1; host_wr_data = 1'b0;
        @(negedge clk); host_wr = 1'b0;
        expect_now("zero write keeps", brk_flag, 1'b1);
        host_clear();
        expect_now("clear works", brk_flag, 1'b0);
        expect_now("irq cleared", brk_irq, 1'b0);

        tag = "R3";
        bits(1'b1, 1);
        bits(1'b0, 6); bits(1'b1, 1); bits(1'b0, 6); bits(1'b1, 1);
        expect_now("split run no flag", brk_flag, 1'b0);

        tag = "R10";
        bits(1'b0, 11);
        @(negedge clk); rxd = 1'b1; idle(3);
        @(negedge clk); rxd = 1'b0;
        bits(1'b0, 1);
        expect_now("off-tick high ignored", brk_flag, 1'b1);
        host_clear();
        bits(1'b1, 1);

        tag = "R8";
        bits(1'b0, 8);
        @(negedge clk); async_mode = 1'b0;
        bits(1'b0, 20);
        expect_now("mode off no flag", brk_flag, 1'b0);
        @(negedge clk); async_mode = 1'b1;
        bits(1'b0, 11);
        expect_now("restart from zero", brk_flag, 1'b0);
        bits(1'b0, 1);
        expect_now("full run after mode on", brk_flag, 1'b1);
        host_clear();
        bits(1'b1, 1);

        tag = "R9";
        bits(1'b0, 11);
        @(negedge clk); rxd = 1'b0; bit_tick = 1'b1; host_wr = 1'b1; host_wr_data = 1'b1;
        @(negedge clk); bit_tick = 1'b0; host_wr = 1'b0; host_wr_data = 1'b0;
        expect_now("set beats clear", brk_flag, 1'b1);
        bits(1'b1, 2);

        idle(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule